// File: doc/BRIEF.md
# Receive Egress with Non-Posted Masking

This block sits between an internal receive buffer and a streaming sink on the application side. It takes packets beat by beat. Each packet carries a type tag (posted, non-posted or completion) and an uncorrectable-error flag. The block stores the packets in two queues: one for non-posted requests, and one shared by posted requests and completions. It sends them to the sink as beats, each with valid, data, start and end flags, the type, and an error indication.

The sink paces delivery with a ready input, and the block answers it two cycles late. A beat may be presented only when ready was high two cycles earlier, and the sink must take every beat shown with valid high. A mask input lets the sink stop new non-posted packets from starting while posted traffic and completions continue. A bounded number of non-posted starts may still get through after the mask rises. A packet is never split: once its first beat has left, its remaining beats follow whatever the mask does. When the mask falls, the non-posted requests that were held go out first, oldest first.

Top module: `rx_egress_mask`

## Requirements
- R1: `out_valid` is high in a cycle only if `sink_ready` was high two cycles earlier, so valid falls no later than two cycles after ready falls.
- R2: With beats stored and `sink_ready` rising after a low period, `out_valid` stays low in the following cycle and is high in the second cycle after the rise.
- R3: Type code 1 is non-posted, 0 is posted and 2 is completion. `in_ready` is high when the queue selected by `in_kind` has room. Every accepted beat reaches the output once, with its data, flags and type unchanged. Beats of posted and completion packets leave in their arrival order, and non-posted beats leave in theirs.
- R4: The output beats of each packet are contiguous. A start beat appears only outside a packet, and every later beat carries the same type until the end beat.
- R5: While `np_mask` is high, at most NP_CAP-1 non-posted packets begin leaving the queues. Counted from the cycle the mask rises, the sink sees no more than NP_CAP non-posted start beats. The allowance restarts each time the mask falls.
- R6: Posted and completion packets keep flowing while `np_mask` is high.
- R7: At a packet boundary, an eligible non-posted packet goes before a waiting posted or completion packet. After the mask falls, held non-posted requests therefore leave before later traffic, in arrival order.
- R8: `out_err[0]` is high exactly on valid beats whose input beat had `in_err` set, and never while `out_valid` is low.
- R9: `out_err[1]` is always zero; bit 0 covers the whole data bus.
- R10: A synchronous reset empties both queues, clears the masking allowance, and holds `out_valid` and `out_err` low. Beats stored before the reset never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Queue for the presented type has room |
| in_data | input | DW | Input beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_kind | input | 2 | Packet type: 0 posted, 1 non-posted, 2 completion |
| in_err | input | 1 | Uncorrectable buffer error on this beat |
| np_mask | input | 1 | Sink request to stop starting non-posted packets |
| sink_ready | input | 1 | Sink can accept beats two cycles later |
| out_valid | output | 1 | Output beat present; the sink must take it |
| out_data | output | DW | Output beat data |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_kind | output | 2 | Type of the packet being sent |
| out_err | output | 2 | Bit 0 error on this beat, bit 1 zero |

## Verification
Two things can fall in the same cycle. The mask can rise while a non-posted start beat is already in the output register, and ready can fall while a masked or unmasked packet is partway through. The sweep runs time-based ready patterns against time-based mask patterns with mixed packet types and lengths, so both coincidences occur many times. Each one is judged at the sink by counting non-posted start beats from the mask's rising cycle against NP_CAP, by a per-class scoreboard for order and contents, and by the two-cycle ready history kept for every valid beat.

// File: rtl/rx_egress_mask.sv
module rx_egress_mask #(
  parameter int DW     = 16,
  parameter int DEPTH  = 8,
  parameter int NP_CAP = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [1:0]    in_kind,
  input  logic          in_err,
  input  logic          np_mask,
  input  logic          sink_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic [1:0]    out_kind,
  output logic [1:0]    out_err
);
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = DW + 5;
  localparam int LIMIT = NP_CAP - 1;
  localparam int CW    = $clog2(NP_CAP + 1);

  logic [EW-1:0] mem [2][DEPTH];
  logic [AW:0]   wp [2];
  logic [AW:0]   rp [2];
  logic [1:0]    full, empty;
  logic          wq, push, pop, sel, avail, np_ok;
  logic          rdy_d1, in_pkt, cur_q, err_q;
  logic [CW-1:0] granted;
  logic [EW-1:0] hd;

  for (genvar q = 0; q < 2; q++) begin : g_q
    assign empty[q] = wp[q] == rp[q];
    assign full[q]  = (wp[q][AW] != rp[q][AW]) && (wp[q][AW-1:0] == rp[q][AW-1:0]);
  end

  assign wq       = in_kind == 2'd1;
  assign in_ready = !full[wq];
  assign push     = in_valid && in_ready;

  assign np_ok = !empty[1] && (!np_mask || granted < CW'(LIMIT));
  assign sel   = in_pkt ? cur_q : np_ok;
  assign avail = in_pkt ? !empty[cur_q] : (np_ok || !empty[0]);
  assign pop   = rdy_d1 && avail;
  assign hd    = mem[sel][rp[sel][AW-1:0]];

  assign out_err = {1'b0, err_q};

  always_ff @(posedge clk)
    if (push) mem[wq][wp[wq][AW-1:0]] <= {in_kind, in_err, in_eop, in_sop, in_data};

  always_ff @(posedge clk) begin
    for (int q = 0; q < 2; q++) begin
      if (rst) begin
        wp[q] <= '0;
        rp[q] <= '0;
      end else begin
        if (push && wq == 1'(q)) wp[q] <= wp[q] + 1'b1;
        if (pop && sel == 1'(q)) rp[q] <= rp[q] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_d1    <= 1'b0;
      out_valid <= 1'b0;
      err_q     <= 1'b0;
      in_pkt    <= 1'b0;
      cur_q     <= 1'b0;
      granted   <= '0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_kind  <= 2'd0;
    end else begin
      rdy_d1    <= sink_ready;
      out_valid <= pop;
      err_q     <= pop && hd[DW+2];
      if (pop) begin
        out_data <= hd[DW-1:0];
        out_sop  <= hd[DW];
        out_eop  <= hd[DW+1];
        out_kind <= hd[DW+4:DW+3];
        in_pkt   <= !hd[DW+1];
        cur_q    <= sel;
      end
      if (!np_mask) granted <= '0;
      else if (pop && sel && !in_pkt) granted <= granted + 1'b1;
    end
  end
endmodule

// File: rtl/rx_egress_mask_chk.sv
module rx_egress_mask_chk #(
  parameter int NP_CAP = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       sink_ready,
  input logic       np_mask,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic [1:0] out_kind,
  input logic [1:0] out_err
);
  logic        open;
  logic [1:0]  kind_q;
  logic [15:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      open   <= 1'b0;
      kind_q <= 2'd0;
      seen   <= '0;
    end else begin
      if (out_valid) begin
        open   <= !out_eop;
        kind_q <= out_kind;
      end
      if (!np_mask) seen <= '0;
      else if (out_valid && out_sop && out_kind == 2'd1 && seen != 16'hffff) seen <= seen + 1'b1;
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(sink_ready, 2));
  // R4
  start_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !open) |-> out_sop);
  // R4
  packet_cont_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && open) |-> (!out_sop && out_kind == kind_q));
  // R5
  np_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (np_mask && out_valid && out_sop && out_kind == 2'd1) |-> (seen < 16'(NP_CAP)));
  // R8
  err_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_err[0] |-> out_valid);
  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_err == 2'b00));
endmodule

bind rx_egress_mask rx_egress_mask_chk #(.NP_CAP(NP_CAP)) u_chk (
  .clk(clk), .rst(rst), .sink_ready(sink_ready), .np_mask(np_mask),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .out_kind(out_kind), .out_err(out_err)
);

// File: tb/test_rx_egress_mask.sv
`timescale 1ns/1ps
module test_rx_egress_mask;
  localparam int DW = 16, DEPTH = 8, NP_CAP = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [1:0] in_kind = 2'd0;
  logic np_mask = 1'b0, sink_ready = 1'b0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [1:0] out_kind, out_err;

  always #4 clk = ~clk;

  rx_egress_mask #(.DW(DW), .DEPTH(DEPTH), .NP_CAP(NP_CAP)) i_rx_egress_mask (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_kind(in_kind), .in_err(in_err),
    .np_mask(np_mask), .sink_ready(sink_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_kind(out_kind), .out_err(out_err)
  );

  typedef struct { logic [DW-1:0] data; logic sop, eop, err; logic [1:0] kind; } beat_t;
  beat_t pcq[$];
  beat_t npq[$];

  int total = 0, bad = 0;
  int seq = 0, np_seen = 0, pc_seen = 0, vcount = 0, msk_cnt = 0;
  logic r_h1 = 0, r_h2 = 0, mask_h1 = 0, open = 0, arm = 0;
  logic [1:0] okind = 0, first_kind = 0;
  logic auto_on = 0;
  int rmode = 0, mmode = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst) begin
      open = 0;
    end else begin
      if (!np_mask) msk_cnt = 0;
      if (out_valid) begin
        beat_t e;
        vcount++;
        check(r_h2 == 1'b1, "R1 ready two cycles earlier", r_h2, 1);
        check(out_err[1] == 1'b0, "R9 err bit1", out_err[1], 0);
        if (!open) check(out_sop == 1'b1, "R4 start outside packet", out_sop, 1);
        else check(!out_sop && out_kind == okind, "R4 continuation", out_kind, okind);
        open = !out_eop;
        okind = out_kind;
        if (out_kind == 2'd1) begin
          if (npq.size() == 0) check(0, "R3 unexpected np beat", out_data, -1);
          else begin
            e = npq.pop_front();
            check(out_data == e.data && out_sop == e.sop && out_eop == e.eop && out_kind == e.kind,
                  "R3 np order", out_data, e.data);
            check(out_err[0] == e.err, "R8 err flag", out_err[0], e.err);
          end
        end else begin
          if (pcq.size() == 0) check(0, "R3 unexpected pc beat", out_data, -1);
          else begin
            e = pcq.pop_front();
            check(out_data == e.data && out_sop == e.sop && out_eop == e.eop && out_kind == e.kind,
                  "R3 posted/completion order", out_data, e.data);
            check(out_err[0] == e.err, "R8 err flag", out_err[0], e.err);
          end
        end
        if (out_sop) begin
          if (arm) begin first_kind = out_kind; arm = 0; end
          if (out_kind == 2'd1) begin
            np_seen++;
            if (np_mask) begin
              msk_cnt++;
              check(msk_cnt <= NP_CAP, "R5 starts since mask rose", msk_cnt, NP_CAP);
            end
          end else pc_seen++;
        end
      end else begin
        check(out_err == 2'b00, "R8 err without valid", out_err, 0);
      end
    end
    r_h2 = r_h1;
    r_h1 = sink_ready;
    mask_h1 = np_mask;
  end

  always @(negedge clk) begin
    if (auto_on) begin
      cyc++;
      case (rmode)
        0: sink_ready = 1'b1;
        1: sink_ready = cyc[0];
        2: sink_ready = cyc[1];
        default: sink_ready = (cyc % 5) < 3;
      endcase
      case (mmode)
        0: np_mask = 1'b0;
        1: np_mask = (cyc % 200) < 100;
        default: np_mask = (cyc % 37) < 18;
      endcase
    end
  end

  task automatic send(input logic [1:0] kind, input int len, input logic err);
    for (int b = 0; b < len; b++) begin
      beat_t e;
      in_valid = 1'b1;
      in_kind = kind;
      in_err = err;
      in_sop = (b == 0);
      in_eop = (b == len - 1);
      in_data = DW'(seq);
      forever begin
        #1;
        if (in_ready) break;
        @(negedge clk);
      end
      e.data = in_data; e.sop = in_sop; e.eop = in_eop; e.err = err; e.kind = kind;
      if (kind == 2'd1) npq.push_back(e); else pcq.push_back(e);
      seq++;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cycles(3);
    #1;
    check(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
    check(out_err == 2'b00, "R10 err in reset", out_err, 0);
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R3 ready when empty", in_ready, 1);
    @(negedge clk);

    // R1, R2: stored beats under a closed sink, then the opening edge
    sink_ready = 1'b0;
    send(2'd0, 2, 1'b0);
    send(2'd1, 1, 1'b1);
    send(2'd2, 3, 1'b0);
    wait_cycles(5);
    #1;
    check(out_valid == 1'b0, "R1 no beats while ready low", out_valid, 0);
    @(negedge clk);
    sink_ready = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R2 valid one cycle after rise", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R2 valid two cycles after rise", out_valid, 1);
    @(negedge clk);
    sink_ready = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    check(out_valid == 1'b0, "R1 valid low two cycles after fall", out_valid, 0);
    @(negedge clk);
    sink_ready = 1'b1;
    wait_cycles(20);
    check(pcq.size() == 0 && npq.size() == 0, "R3 all delivered", pcq.size() + npq.size(), 0);

    // R5, R6: cap under mask with open sink
    np_mask = 1'b1;
    np_seen = 0; pc_seen = 0;
    @(negedge clk);
    for (int i = 0; i < 14; i++) send(2'd1, 1, 1'b0);
    send(2'd0, 2, 1'b0);
    send(2'd2, 2, 1'b1);
    wait_cycles(40);
    check(np_seen == NP_CAP - 1, "R5 np starts while masked", np_seen, NP_CAP - 1);
    check(pc_seen == 2, "R6 posted/completion flow while masked", pc_seen, 2);
    check(npq.size() == 14 - (NP_CAP - 1), "R5 np held", npq.size(), 14 - (NP_CAP - 1));

    // R7: held np goes before queued posted traffic once mask falls
    sink_ready = 1'b0;
    send(2'd0, 3, 1'b0);
    send(2'd2, 1, 1'b0);
    wait_cycles(4);
    arm = 1'b1;
    np_mask = 1'b0;
    sink_ready = 1'b1;
    wait_cycles(40);
    check(first_kind == 2'd1, "R7 held np first after unmask", first_kind, 1);
    check(npq.size() == 0 && pcq.size() == 0, "R7 all released", npq.size() + pcq.size(), 0);

    // R5: allowance restarts after the mask fell
    np_mask = 1'b1;
    np_seen = 0;
    @(negedge clk);
    for (int i = 0; i < 12; i++) send(2'd1, 1, 1'b0);
    wait_cycles(30);
    check(np_seen == NP_CAP - 1, "R5 allowance restarts", np_seen, NP_CAP - 1);
    np_mask = 1'b0;
    wait_cycles(30);
    check(npq.size() == 0, "R5 remainder after unmask", npq.size(), 0);

    // R3, R4, R8: sweep of ready and mask patterns
    for (int rm = 0; rm < 4; rm++) begin
      for (int mm = 0; mm < 3; mm++) begin
        rmode = rm; mmode = mm; cyc = 0;
        auto_on = 1'b1;
        for (int i = 0; i < 20; i++)
          send(2'((i * 7 + rm + mm) % 3), 1 + (i * 5 + rm) % 4, (i % 5) == 3);
        @(negedge clk);
        auto_on = 1'b0;
        sink_ready = 1'b1;
        np_mask = 1'b0;
        wait_cycles(60);
        check(pcq.size() == 0 && npq.size() == 0, "R3 sweep drained",
              pcq.size() + npq.size(), 0);
        check(open == 1'b0, "R4 sweep ends between packets", open, 0);
      end
    end

    // R10: reset discards stored beats
    sink_ready = 1'b0;
    send(2'd0, 2, 1'b1);
    send(2'd1, 2, 1'b0);
    send(2'd2, 1, 1'b0);
    rst = 1'b1;
    wait_cycles(2);
    pcq.delete();
    npq.delete();
    rst = 1'b0;
    vcount = 0;
    sink_ready = 1'b1;
    wait_cycles(8);
    check(vcount == 0, "R10 no beats after reset", vcount, 0);
    in_kind = 2'd1; #1;
    check(in_ready == 1'b1, "R10 np queue empty", in_ready, 1);
    in_kind = 2'd0; #1;
    check(in_ready == 1'b1, "R10 posted queue empty", in_ready, 1);
    @(negedge clk);
    send(2'd2, 2, 1'b1);
    wait_cycles(10);
    check(pcq.size() == 0, "R10 traffic resumes", pcq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule